// File: doc/BRIEF.md
# Reset Cause and Break Status Registers

This block keeps two small software-visible registers for a microcontroller's system-integration logic. The first tells firmware what caused the most recent reset. The second tells a debug handler whether a break interrupt ended a low-power wait state.

The reset sources deliver single-cycle pulses to the block. The block's synchronous reset input is the power-on reset. Every other reset cause is a pulse, and none of those pulses reinitializes the block. As a result, the cause flags survive into the code that runs after any reset other than power-on. Reading the reset-cause register returns the flags and clears them in the same access. The break flag is set by a break-exit pulse and is cleared when software writes 0 to it.

Both registers sit behind a simple single-cycle read/write bus. The break status register is at `BASE_ADDR` and the reset-cause register is at `BASE_ADDR + 1`. Read data is registered.

Top module: `rst_cause_regs`

## Requirements
- R1: While `rst` is high, the reset-cause register is loaded with 0x80 and the break register with 0x00, whatever flags were set before. The first cycle after `rst` falls sees these values.
- R2: The bus reads the break register at `BASE_ADDR` and the reset-cause register at `BASE_ADDR + 1`. In the reset-cause byte, bit 7 is power-on, bit 6 is external pin, bit 5 is watchdog, bit 4 is illegal opcode, bit 3 is illegal address and bit 1 is low-voltage. Bits 2 and 0 always read 0.
- R3: A pulse on a single non-power-on cause sets that cause's flag and clears all other flags on the next clock edge. The register then holds exactly one set bit.
- R4: When several non-power-on causes pulse in the same cycle, only the highest-numbered bit among them is set (pin over watchdog over illegal opcode over illegal address over low-voltage).
- R5: A read of the reset-cause register returns the flags as they stood before the read on `bus_rdata_o` one cycle after the request. The flags are 0 from that same edge on.
- R6: When a cause pulse and a reset-cause read fall in the same cycle, the read returns the old flags and the register then holds the new cause alone.
- R7: With no cause pulse and no reset-cause read, the flags hold their value. A write to the reset-cause address has no effect.
- R8: A `brk_exit_i` pulse sets bit 1 of the break register. Every other bit of that register reads 0.
- R9: A write to the break register with bit 1 at 0 clears the flag. A write with bit 1 at 1 leaves it as it is. If a set pulse and a clearing write coincide, the flag ends up set.
- R10: A read of any other address returns 0. `bus_rdata_o` is 0 in every cycle that follows a cycle with no read request.
- R11: Reading the break register does not clear it, and non-power-on cause pulses do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pin_rst_i | input | 1 | External pin reset pulse |
| wdog_rst_i | input | 1 | Watchdog reset pulse |
| illop_rst_i | input | 1 | Illegal opcode reset pulse |
| illadr_rst_i | input | 1 | Illegal address reset pulse |
| lvd_rst_i | input | 1 | Low-voltage reset pulse |
| brk_exit_i | input | 1 | Wait state was left because of a break interrupt |
| bus_sel_i | input | 1 | Bus access request |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |

## Verification
The bench builds the block with `ADDR_W = 4` and `BASE_ADDR = 6`. With these values the two registers sit at 6 and 7, away from address 0. Any decoder that ignores the base offset therefore shows up. The neighbouring addresses 5 and 8 can be read to confirm that nothing else aliases onto the registers. Address 8 also exercises the carry out of the low address bits.

// File: rtl/rcause_pkg.sv
package rcause_pkg;
  localparam int STAT_W     = 8;
  localparam int POS_POR    = 7;
  localparam int POS_PIN    = 6;
  localparam int POS_WDOG   = 5;
  localparam int POS_ILLOP  = 4;
  localparam int POS_ILLADR = 3;
  localparam int POS_LVD    = 1;

  typedef struct packed {
    logic pin;
    logic wdog;
    logic illop;
    logic illadr;
    logic lvd;
  } src_t;
endpackage

// File: rtl/rcause_latch.sv
module rcause_latch
  import rcause_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  src_t              src_i,
  input  logic              rd_clr_i,
  output logic [STAT_W-1:0] flags_o
);
  logic [STAT_W-1:0] flags_q;
  logic [STAT_W-1:0] cause_vec;
  logic              any_cause;

  // priority: pin > watchdog > illegal opcode > illegal address > low-voltage
  always_comb begin
    cause_vec = '0;
    if (src_i.pin)         cause_vec[POS_PIN]    = 1'b1;
    else if (src_i.wdog)   cause_vec[POS_WDOG]   = 1'b1;
    else if (src_i.illop)  cause_vec[POS_ILLOP]  = 1'b1;
    else if (src_i.illadr) cause_vec[POS_ILLADR] = 1'b1;
    else if (src_i.lvd)    cause_vec[POS_LVD]    = 1'b1;
  end

  assign any_cause = |src_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= STAT_W'(1) << POS_POR;
    end else if (any_cause) begin
      flags_q <= cause_vec;
    end else if (rd_clr_i) begin
      flags_q <= '0;
    end
  end

  assign flags_o = flags_q;

  // R1
  por_value_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> flags_q == 8'h80);
  // R2
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
    flags_q[2] == 1'b0 && flags_q[0] == 1'b0);
  // R3
  one_cause_chk: assert property (@(posedge clk) disable iff (rst)
    any_cause |=> $onehot(flags_q));
  // R4
  pin_wins_chk: assert property (@(posedge clk) disable iff (rst)
    src_i.pin |=> flags_q == 8'h40);
  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr_i && !any_cause) |=> flags_q == '0);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_clr_i && !any_cause) |=> $stable(flags_q));
endmodule

// File: rtl/brk_flag.sv
module brk_flag #(
  parameter int W       = 8,
  parameter int BRK_BIT = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] reg_o
);
  localparam logic [W-1:0] MASK = W'(1) << BRK_BIT;

  logic [W-1:0] reg_q;
  logic [W-1:0] keep_mask;

  // a write of 0 clears an implemented bit; a write of 1 keeps it
  assign keep_mask = wr_i ? (wdata_i | ~MASK) : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q <= '0;
    end else begin
      reg_q <= ((reg_q & keep_mask) | (set_i ? MASK : '0)) & MASK;
    end
  end

  assign reg_o = reg_q;

  // R8
  brk_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> reg_q[BRK_BIT]);
  // R8
  brk_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_q & ~MASK) == '0);
  // R9
  brk_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !wdata_i[BRK_BIT] && !set_i) |=> !reg_q[BRK_BIT]);
  // R11
  brk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_i && !set_i) |=> $stable(reg_q));
endmodule

// File: rtl/rcause_busmux.sv
module rcause_busmux #(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int                W         = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      brk_reg_i,
  input  logic [W-1:0]      stat_reg_i,
  output logic              stat_rd_o,
  output logic              brk_wr_o,
  output logic [W-1:0]      rdata_o
);
  localparam logic [ADDR_W-1:0] BRK_ADDR  = BASE_ADDR;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(BASE_ADDR + 1'b1);

  logic         rd_req;
  logic [W-1:0] rdata_q;

  assign rd_req    = sel_i && !wr_i;
  assign stat_rd_o = rd_req && (addr_i == STAT_ADDR);
  assign brk_wr_o  = sel_i && wr_i && (addr_i == BRK_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_req && addr_i == BRK_ADDR) begin
      rdata_q <= brk_reg_i;
    end else if (stat_rd_o) begin
      rdata_q <= stat_reg_i;
    end else begin
      rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;

  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> rdata_q == '0);
  // R5
  stat_read_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd_o |=> rdata_q == $past(stat_reg_i));
endmodule

// File: rtl/rst_cause_regs.sv
module rst_cause_regs
  import rcause_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int                BRK_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_rst_i,
  input  logic              wdog_rst_i,
  input  logic              illop_rst_i,
  input  logic              illadr_rst_i,
  input  logic              lvd_rst_i,
  input  logic              brk_exit_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [STAT_W-1:0] bus_wdata_i,
  output logic [STAT_W-1:0] bus_rdata_o
);
  src_t              src;
  logic              stat_rd;
  logic              brk_wr;
  logic [STAT_W-1:0] stat_reg;
  logic [STAT_W-1:0] brk_reg;

  assign src = '{pin: pin_rst_i, wdog: wdog_rst_i, illop: illop_rst_i,
                 illadr: illadr_rst_i, lvd: lvd_rst_i};

  rcause_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .src_i    (src),
    .rd_clr_i (stat_rd),
    .flags_o  (stat_reg)
  );

  brk_flag #(.W(STAT_W), .BRK_BIT(BRK_BIT)) u_brk (
    .clk     (clk),
    .rst     (rst),
    .set_i   (brk_exit_i),
    .wr_i    (brk_wr),
    .wdata_i (bus_wdata_i),
    .reg_o   (brk_reg)
  );

  rcause_busmux #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .W(STAT_W)) u_bus (
    .clk        (clk),
    .rst        (rst),
    .sel_i      (bus_sel_i),
    .wr_i       (bus_wr_i),
    .addr_i     (bus_addr_i),
    .brk_reg_i  (brk_reg),
    .stat_reg_i (stat_reg),
    .stat_rd_o  (stat_rd),
    .brk_wr_o   (brk_wr),
    .rdata_o    (bus_rdata_o)
  );

  // R6
  collide_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && lvd_rst_i && !pin_rst_i && !wdog_rst_i && !illop_rst_i && !illadr_rst_i)
      |=> stat_reg == 8'h02);
endmodule

// File: tb/rst_cause_regs_tb_top.sv
`timescale 1ns/1ps
module rst_cause_regs_tb_top;
  localparam logic [3:0] BRK_A  = 4'h6;
  localparam logic [3:0] STAT_A = 4'h7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin = 0, wdog = 0, illop = 0, illadr = 0, lvd = 0, brk = 0;
  logic       sel = 0, wr = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rst_cause_regs #(.ADDR_W(4), .BASE_ADDR(4'h6), .BRK_BIT(1)) dut_i (
    .clk(clk), .rst(rst),
    .pin_rst_i(pin), .wdog_rst_i(wdog), .illop_rst_i(illop),
    .illadr_rst_i(illadr), .lvd_rst_i(lvd), .brk_exit_i(brk),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // cause vector order: {pin, wdog, illop, illadr, lvd}
  task automatic pulse(input logic [4:0] v, input logic b);
    @(negedge clk);
    {pin, wdog, illop, illadr, lvd} = v;
    brk = b;
    @(negedge clk);
    {pin, wdog, illop, illadr, lvd} = '0;
    brk = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1; wr = 0; addr = a;
    @(negedge clk);
    d = rdata;
    sel = 0;
  endtask

  task automatic wrt(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    rd(STAT_A, d); chk("R1 power-on status", d, 8'h80);
    rd(BRK_A, d);  chk("R1 power-on break", d, 8'h00);
    rd(STAT_A, d); chk("R5 cleared after read", d, 8'h00);
  endtask

  task automatic t_each_cause();
    logic [7:0] d;
    logic [7:0] exp [5] = '{8'h40, 8'h20, 8'h10, 8'h08, 8'h02};
    for (int i = 0; i < 5; i++) begin
      pulse(5'b10000 >> i, 1'b0);
      rd(STAT_A, d); chk("R3 single cause flag (R2 layout)", d, exp[i]);
      rd(STAT_A, d); chk("R5 flags clear after read", d, 8'h00);
    end
    pulse(5'b00010, 1'b0);
    pulse(5'b00001, 1'b0);
    rd(STAT_A, d); chk("R3 later cause replaces earlier", d, 8'h02);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    pulse(5'b10001, 1'b0);
    rd(STAT_A, d); chk("R4 pin over low-voltage", d, 8'h40);
    pulse(5'b01010, 1'b0);
    rd(STAT_A, d); chk("R4 watchdog over illegal address", d, 8'h20);
    pulse(5'b00111, 1'b0);
    rd(STAT_A, d); chk("R4 illegal opcode over lower causes", d, 8'h10);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    pulse(5'b10000, 1'b0);
    @(negedge clk);
    sel = 1; wr = 0; addr = STAT_A; wdog = 1;
    @(negedge clk);
    d = rdata; sel = 0; wdog = 0;
    chk("R6 read returns old flags", d, 8'h40);
    rd(STAT_A, d); chk("R6 new cause survives read", d, 8'h20);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    pulse(5'b00100, 1'b0);
    repeat (4) @(negedge clk);
    wrt(STAT_A, 8'hFF);
    wrt(STAT_A, 8'h00);
    rd(STAT_A, d); chk("R7 flags held, writes ignored", d, 8'h10);
  endtask

  task automatic t_break();
    logic [7:0] d;
    pulse(5'b00000, 1'b1);
    rd(BRK_A, d); chk("R8 break flag in bit 1", d, 8'h02);
    rd(BRK_A, d); chk("R11 break read does not clear", d, 8'h02);
    pulse(5'b11111, 1'b0);
    rd(BRK_A, d); chk("R11 break survives cause pulses", d, 8'h02);
    wrt(BRK_A, 8'hFF);
    rd(BRK_A, d); chk("R9 writing 1 keeps flag", d, 8'h02);
    wrt(BRK_A, 8'hFD);
    rd(BRK_A, d); chk("R9 writing 0 clears flag", d, 8'h00);
    wrt(BRK_A, 8'hFF);
    rd(BRK_A, d); chk("R8 reserved bits read 0", d, 8'h00);
    @(negedge clk);
    sel = 1; wr = 1; addr = BRK_A; wdata = 8'h00; brk = 1;
    @(negedge clk);
    sel = 0; wr = 0; brk = 0;
    rd(BRK_A, d); chk("R9 set wins over clearing write", d, 8'h02);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    pulse(5'b01000, 1'b1);
    rd(4'h5, d); chk("R10 address below base reads 0", d, 8'h00);
    rd(4'h8, d); chk("R10 address above status reads 0", d, 8'h00);
    @(negedge clk);
    chk("R10 idle read data 0", rdata, 8'h00);
    rd(STAT_A, d); chk("R2 status at base+1", d, 8'h20);
  endtask

  task automatic t_por_over_flags();
    logic [7:0] d;
    pulse(5'b00001, 1'b1);
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    rd(STAT_A, d); chk("R1 power-on wipes prior flags", d, 8'h80);
    rd(BRK_A, d);  chk("R1 power-on clears break", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset_state();
    t_each_cause();
    t_priority();
    t_collision();
    t_hold();
    t_break();
    t_unmapped();
    t_por_over_flags();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule